// File: doc/BRIEF.md
# USB endpoint DMA request selector

This block turns USB endpoint FIFO status into DMA trigger lines for two DMA channels. Each channel owns an 8-bit select register, written and read through a small register port. Each bit of the register names one endpoint FIFO event. The low nibble covers IN FIFO writes on endpoints 1 to 4. The high nibble covers OUT FIFO reads on the same endpoints.

A channel raises its request while the packet-ready flag of its chosen endpoint is set. The request also needs two qualifiers: USB must be that channel's chosen DMA source, and that channel's DMA must be enabled. A select value with no bit set, or with more than one bit set, is treated as choosing nothing. The DMA engine, the USB protocol logic and the FIFO storage sit outside this block.

Top module: `usb_dma_req_sel`

## Requirements
- R1: After reset both select registers read 0x00 and both `dma_req` bits are 0.
- R2: A cycle with `reg_we`=1 stores `reg_wdata` into the register picked by `reg_addr` (0 = channel 0, 1 = channel 1). `reg_rdata` returns the stored value of the addressed register unchanged, including every bit of a multi-bit value.
- R3: Select bit k (k = 0..3) picks `in_rdy[k]`, the IN packet-ready flag of endpoint k+1.
- R4: Select bit 4+k (k = 0..3) picks `out_rdy[k]`, the OUT packet-ready flag of endpoint k+1.
- R5: A select value with two or more bits set produces no request, whatever the flags are.
- R6: A select value of 0x00 produces no request.
- R7: A channel requests only while its `usb_src` bit is 1.
- R8: A channel requests only while its `dma_en` bit is 1.
- R9: `dma_req` is registered. It rises on the first clock edge at which every condition holds, and it falls on the first edge at which any condition is false. A write that makes the select invalid blocks the request from the next edge on.
- R10: The two channels are independent. Writing one channel's register leaves the other's value unchanged, and each request uses only its own register, source bit and enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Channel select for register access |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register value (combinational) |
| in_rdy | input | 4 | IN packet-ready flags, bit k = endpoint k+1 |
| out_rdy | input | 4 | OUT packet-ready flags, bit k = endpoint k+1 |
| usb_src | input | 2 | Per channel: USB chosen as DMA request source |
| dma_en | input | 2 | Per channel: DMA enable |
| dma_req | output | 2 | Per channel registered DMA request |

## Verification
The assertions assume that `reg_addr` addresses only the two existing channels. They also assume that every input is a known value after reset, so that `$countones` and `$past` on the stored selects and the gating inputs are meaningful. The stimulus keeps to this by construction. The address is always drawn as a single bit, and every input is driven to a defined value before reset is released. Each input changes only on the falling clock edge, away from the edge at which the register and the request flop sample.

// File: rtl/usb_dma_req_sel.sv
module usb_dma_req_sel #(
  parameter int NUM_CH = 2,
  parameter int NUM_EP = 4,
  parameter int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [CH_AW-1:0]    reg_addr,
  input  logic [2*NUM_EP-1:0] reg_wdata,
  output logic [2*NUM_EP-1:0] reg_rdata,
  input  logic [NUM_EP-1:0]   in_rdy,
  input  logic [NUM_EP-1:0]   out_rdy,
  input  logic [NUM_CH-1:0]   usb_src,
  input  logic [NUM_CH-1:0]   dma_en,
  output logic [NUM_CH-1:0]   dma_req
);
  localparam int SEL_W = 2 * NUM_EP;

  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
  logic [SEL_W-1:0]             events;
  logic [NUM_CH-1:0]            fire;

  assign events    = {out_rdy, in_rdy};
  assign reg_rdata = sel_q[reg_addr];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic single;
    assign single  = (sel_q[c] != '0) && ((sel_q[c] & (sel_q[c] - 1'b1)) == '0);
    assign fire[c] = single && |(sel_q[c] & events) && usb_src[c] && dma_en[c];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        sel_q[c] <= '0;
      else if (reg_we && reg_addr == CH_AW'(c))
        sel_q[c] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dma_req <= '0;
    else        dma_req <= fire;
endmodule

module usb_dma_req_sel_chk #(
  parameter int NUM_CH = 2,
  parameter int NUM_EP = 4,
  parameter int CH_AW  = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_we,
  input logic [CH_AW-1:0]                 reg_addr,
  input logic [2*NUM_EP-1:0]              reg_wdata,
  input logic [NUM_EP-1:0]                in_rdy,
  input logic [NUM_EP-1:0]                out_rdy,
  input logic [NUM_CH-1:0]                usb_src,
  input logic [NUM_CH-1:0]                dma_en,
  input logic [NUM_CH-1:0]                dma_req,
  input logic [NUM_CH-1:0][2*NUM_EP-1:0]  sel
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past(dma_en[c]));
    // R7
    req_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past(usb_src[c]));
    // R5
    req_single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past($countones(sel[c]) == 1));
    // R3
    req_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> $past(|(sel[c] & {out_rdy, in_rdy})));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == CH_AW'(c)) |=> sel[c] == $past(reg_wdata));
    // R10
    other_ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we || reg_addr != CH_AW'(c)) |=> $stable(sel[c]));
  end
endmodule

bind usb_dma_req_sel usb_dma_req_sel_chk #(
  .NUM_CH(NUM_CH), .NUM_EP(NUM_EP), .CH_AW(CH_AW)
) i_usb_dma_req_sel_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .usb_src(usb_src), .dma_en(dma_en), .dma_req(dma_req), .sel(sel_q)
);

// File: tb/test_usb_dma_req_sel.sv
`timescale 1ns/1ps
module test_usb_dma_req_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [0:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] in_rdy = '0;
  logic [3:0] out_rdy = '0;
  logic [1:0] usb_src = '0;
  logic [1:0] dma_en = '0;
  logic [1:0] dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] shadow [2];

  always #5 clk = ~clk;

  usb_dma_req_sel i_usb_dma_req_sel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_rdy(in_rdy),
    .out_rdy(out_rdy), .usb_src(usb_src), .dma_en(dma_en), .dma_req(dma_req)
  );

  function automatic bit want(logic [7:0] s, logic [3:0] i, logic [3:0] o, bit src, bit en);
    return ($countones(s) == 1) && ((s & {o, i}) != 8'h00) && src && en;
  endfunction

  function automatic logic [1:0] want2();
    return {want(shadow[1], in_rdy, out_rdy, usb_src[1], dma_en[1]),
            want(shadow[0], in_rdy, out_rdy, usb_src[0], dma_en[0])};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit ch, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ch; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow[ch] = d;
  endtask

  task automatic rd(string req, bit ch);
    @(negedge clk);
    reg_addr = ch;
    #1 chk(req, reg_rdata, shadow[ch]);
  endtask

  task automatic drive(logic [3:0] i, logic [3:0] o, logic [1:0] s, logic [1:0] e);
    @(negedge clk);
    in_rdy = i; out_rdy = o; usb_src = s; dma_en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic req_chk(string req, logic [3:0] i, logic [3:0] o, logic [1:0] s, logic [1:0] e);
    drive(i, o, s, e);
    chk(req, {6'd0, dma_req}, {6'd0, want2()});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    shadow[0] = 8'h00; shadow[1] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd("R1", 1'b0);
    rd("R1", 1'b1);
    #1 chk("R1", {6'd0, dma_req}, 8'h00);

    // R2 readback of multi-bit values, R10 other channel untouched
    wr(1'b0, 8'hA5); rd("R2", 1'b0); rd("R10", 1'b1);
    wr(1'b1, 8'h3C); rd("R2", 1'b1); rd("R10", 1'b0);

    // R3, R4 every single-bit select against every flag pattern
    for (int ch = 0; ch < 2; ch++) begin
      wr(ch[0], 8'h00); wr(!ch[0], 8'h00);
      for (int b = 0; b < 8; b++) begin
        wr(ch[0], 8'(1 << b));
        for (int f = 0; f < 256; f++)
          req_chk(b < 4 ? "R3" : "R4", f[3:0], f[7:4], 2'b11, 2'b11);
      end
    end

    // R5 multi-bit values never request
    foreach (shadow[c]) shadow[c] = shadow[c];
    begin
      logic [7:0] multi [5] = '{8'h03, 8'h11, 8'h81, 8'hFF, 8'h28};
      foreach (multi[m]) begin
        wr(1'b0, multi[m]); wr(1'b1, multi[m]);
        req_chk("R5", 4'hF, 4'hF, 2'b11, 2'b11);
        chk("R5", {6'd0, dma_req}, 8'h00);
      end
    end

    // R6 zero select
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    req_chk("R6", 4'hF, 4'hF, 2'b11, 2'b11);
    chk("R6", {6'd0, dma_req}, 8'h00);

    // R7, R8 each gate dropped alone; R10 per-channel gating
    wr(1'b0, 8'h04); wr(1'b1, 8'h40);
    req_chk("R10", 4'h4, 4'h4, 2'b11, 2'b11);
    chk("R10", {6'd0, dma_req}, 8'h03);
    req_chk("R7", 4'h4, 4'h4, 2'b10, 2'b11);
    chk("R7", {6'd0, dma_req}, 8'h02);
    req_chk("R7", 4'h4, 4'h4, 2'b01, 2'b11);
    chk("R7", {6'd0, dma_req}, 8'h01);
    req_chk("R8", 4'h4, 4'h4, 2'b11, 2'b10);
    chk("R8", {6'd0, dma_req}, 8'h02);
    req_chk("R8", 4'h4, 4'h4, 2'b11, 2'b01);
    chk("R8", {6'd0, dma_req}, 8'h01);

    // R9 one-edge latency on rise and fall, invalid write blocks next edge
    drive(4'h0, 4'h0, 2'b11, 2'b11);
    @(negedge clk);
    in_rdy = 4'h4;
    #1 chk("R9", {6'd0, dma_req}, 8'h00);
    @(posedge clk); #1 chk("R9", {6'd0, dma_req}, 8'h01);
    @(negedge clk);
    dma_en = 2'b10;
    #1 chk("R9", {6'd0, dma_req}, 8'h01);
    @(posedge clk); #1 chk("R9", {6'd0, dma_req}, 8'h00);
    drive(4'h4, 4'h0, 2'b11, 2'b11);
    chk("R9", {6'd0, dma_req}, 8'h01);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h0C;
    @(posedge clk); #1 chk("R9", {6'd0, dma_req}, 8'h01);
    @(negedge clk); reg_we = 1'b0; shadow[0] = 8'h0C;
    @(posedge clk); #1 chk("R9", {6'd0, dma_req}, 8'h00);

    // random mix
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        bit ch = 1'($urandom);
        logic [7:0] d = ($urandom_range(0, 2) != 0) ? 8'(1 << $urandom_range(0, 7)) : 8'($urandom);
        wr(ch, d);
        rd("R2", ch);
      end
      req_chk("R9", 4'($urandom), 4'($urandom), 2'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule